// File: doc/BRIEF.md
# Shared-Counter Four-Channel PWM Generator

This block produces four pulse-width-modulated channels from one common time base. A prescaler divides the input clock, and a single up-counter runs from zero to a reload value and then wraps. Each channel compares that counter with its own compare value. The result drives a true output and a complementary output. Each of these two outputs has its own enable bit and its own polarity bit. A main gate forces all eight lines low until it is opened.

Software programs the block through a one-cycle write port. The reload, compare and prescaler values each sit behind a shadow register. When the preload mode is on, a new reload or compare value takes effect only at an update event. An update event is a counter wrap or a forced update written by software. This lets software change a waveform without producing a glitched period. A forced update also restarts the counter and the prescaler, so the channels can be brought to a known phase.

Top module: `pwm_quad_core`

## Requirements
- R1: While the run bit is set (address 0, bit 0), the counter advances once every prescaler+1 clocks. It steps from 0 up to the reload value and then wraps to 0, so one period lasts (reload+1)*(prescaler+1) clocks.
- R2: A channel's reference level is high while the counter is below that channel's compare value. A compare value of 0 gives a constant low level, and a compare value above the reload value gives a constant high level.
- R3: A true output equals the reference level XOR its invert bit. A complementary output equals the inverse of the reference level XOR its own invert bit.
- R4: Address 4 holds one nibble per channel. For channel c, bit 4c+0 enables the true output, bit 4c+1 inverts it, bit 4c+2 enables the complementary output and bit 4c+3 inverts it. An output whose enable bit is clear stays at 0.
- R5: While bit 16 of address 4 (the main gate) is clear, all eight outputs are 0.
- R6: With the preload bit set (address 0, bit 1), a value written to the reload register (address 2) or to a compare register (address 8+c) changes nothing until the next update event.
- R7: With the preload bit clear, a value written to the reload register or to a compare register is in use from the clock edge that accepts the write.
- R8: Writing 1 to bit 0 of address 3 causes an update event at that edge. The event loads all shadow registers and sets the counter and the prescaler count to 0.
- R9: If a write to a shadowed register lands on the same edge as a wrap, the value just written is loaded and used from the wrap onward.
- R10: While the run bit is clear, the counter holds its value.
- R11: A value written to the prescaler register (address 1) takes effect only at an update event, whatever the preload bit holds.
- R12: After reset all outputs are 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Register address |
| wr_data | input | CNT_W | Write data |
| pwm_p | output | NUM_CH | True PWM outputs |
| pwm_n | output | NUM_CH | Complementary PWM outputs |

## Verification
Two events can fall on the same clock edge: a register write and the counter wrap that loads the shadows. The bench provokes this by issuing a compare write in the cycle just before a wrap. It then checks that the following period already uses the new duty. A second pairing places a forced update in the middle of a prescaled count. The bench judges this case by whether the waveform restarts from counter zero with a full prescaler interval.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_PSC      = 4'd1;
    localparam logic [ADDR_W-1:0] A_RELOAD   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FORCE    = 4'd3;
    localparam logic [ADDR_W-1:0] A_OUTCFG   = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd8;

    localparam int GATE_BIT = 16;

    // one nibble per channel, lowest bit first: on, inv, cmp_on, cmp_inv
    typedef struct packed {
        logic cmp_inv;
        logic cmp_on;
        logic inv;
        logic on;
    } chan_cfg_t;

    typedef struct packed {
        logic preload;
        logic run;
    } ctrl_t;

    // returns {complementary, true}
    function automatic logic [1:0] drive_pair(input logic ref_hi,
                                              input chan_cfg_t cfg,
                                              input logic gate);
        logic t;
        logic n;
        t = gate & cfg.on & (ref_hi ^ cfg.inv);
        n = gate & cfg.cmp_on & (~ref_hi ^ cfg.cmp_inv);
        return {n, t};
    endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  logic                           ovf,
    output logic                           run,
    output logic                           preload,
    output logic                           force_upd,
    output logic                           gate,
    output logic [CNT_W-1:0]               psc_act,
    output logic [CNT_W-1:0]               arr_act,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_act,
    output chan_cfg_t [NUM_CH-1:0]         cfg
);

    localparam int CFG_W = 4 * NUM_CH;

    ctrl_t                  ctrl_q;
    logic [CNT_W-1:0]       psc_pre, arr_pre;
    logic [CNT_W-1:0]       psc_nxt, arr_nxt;
    logic                   uev;
    logic                   wr_psc, wr_arr, wr_cfg;

    assign wr_psc    = wr_en && (wr_addr == A_PSC);
    assign wr_arr    = wr_en && (wr_addr == A_RELOAD);
    assign wr_cfg    = wr_en && (wr_addr == A_OUTCFG);
    assign force_upd = wr_en && (wr_addr == A_FORCE) && wr_data[0];
    assign uev       = ovf | force_upd;
    assign run       = ctrl_q.run;
    assign preload   = ctrl_q.preload;

    // value the shadow holds after this edge; an update loads this one
    always_comb begin
        psc_nxt = wr_psc ? wr_data : psc_pre;
        arr_nxt = wr_arr ? wr_data : arr_pre;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            psc_pre <= '0;
            psc_act <= '0;
            arr_pre <= '1;
            arr_act <= '1;
            gate    <= 1'b0;
            cfg     <= '0;
        end else begin
            if (wr_en && (wr_addr == A_CTRL))
                ctrl_q <= ctrl_t'(wr_data[1:0]);
            if (wr_cfg) begin
                cfg  <= wr_data[CFG_W-1:0];
                gate <= wr_data[GATE_BIT];
            end
            psc_pre <= psc_nxt;
            arr_pre <= arr_nxt;
            if (uev)
                psc_act <= psc_nxt;
            if (uev || (wr_arr && !ctrl_q.preload))
                arr_act <= arr_nxt;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
        logic             hit;
        logic [CNT_W-1:0] pre_q, act_q, nxt;

        assign hit = wr_en && (wr_addr == ADDR_W'(int'(A_CMP_BASE) + c));
        assign nxt = hit ? wr_data : pre_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pre_q <= '0;
                act_q <= '0;
            end else begin
                pre_q <= nxt;
                if (uev || (hit && !ctrl_q.preload))
                    act_q <= nxt;
            end
        end

        assign cmp_act[c] = act_q;
    end

endmodule

// File: rtl/pwm_quad_timebase.sv
module pwm_quad_timebase #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             force_upd,
    input  logic [CNT_W-1:0] psc_act,
    input  logic [CNT_W-1:0] arr_act,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W-1:0] div_q;
    logic             tick;
    logic             at_top;

    // >= keeps the counter bounded if the limit drops below it
    assign tick   = (div_q >= psc_act);
    assign at_top = (cnt >= arr_act);
    assign ovf    = run && tick && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (force_upd) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (run) begin
            if (tick) begin
                div_q <= '0;
                cnt   <= at_top ? '0 : cnt + 1'b1;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_quad_outstage.sv
module pwm_quad_outstage
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic [CNT_W-1:0]             cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
    input  chan_cfg_t [NUM_CH-1:0]       cfg,
    input  logic                         gate,
    output logic [NUM_CH-1:0]            pwm_p,
    output logic [NUM_CH-1:0]            pwm_n
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic ref_hi;
        assign ref_hi = (cnt < cmp_act[c]);
        assign {pwm_n[c], pwm_p[c]} = drive_pair(ref_hi, cfg[c], gate);
    end

endmodule

// File: rtl/pwm_quad_core.sv
module pwm_quad_core
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output logic [NUM_CH-1:0]   pwm_p,
    output logic [NUM_CH-1:0]   pwm_n
);

    logic                         run_w, preload_w, force_w, gate_w, ovf_w;
    logic [CNT_W-1:0]             psc_w, arr_w, cnt_w;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_w;
    chan_cfg_t [NUM_CH-1:0]       cfg_w;

    pwm_quad_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ovf       (ovf_w),
        .run       (run_w),
        .preload   (preload_w),
        .force_upd (force_w),
        .gate      (gate_w),
        .psc_act   (psc_w),
        .arr_act   (arr_w),
        .cmp_act   (cmp_w),
        .cfg       (cfg_w)
    );

    pwm_quad_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .run       (run_w),
        .force_upd (force_w),
        .psc_act   (psc_w),
        .arr_act   (arr_w),
        .cnt       (cnt_w),
        .ovf       (ovf_w)
    );

    pwm_quad_outstage #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_out (
        .cnt     (cnt_w),
        .cmp_act (cmp_w),
        .cfg     (cfg_w),
        .gate    (gate_w),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n)
    );

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk
    import pwm_quad_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   run,
    input  logic                   preload,
    input  logic                   force_upd,
    input  logic                   gate,
    input  logic                   ovf,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [CNT_W-1:0]       arr_act,
    input  chan_cfg_t [NUM_CH-1:0] cfg,
    input  logic [NUM_CH-1:0]      pwm_p,
    input  logic [NUM_CH-1:0]      pwm_n
);

    // R10
    hold_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !force_upd) |=> $stable(cnt));

    // R8
    force_clear_chk: assert property (@(posedge clk) disable iff (rst)
        force_upd |=> (cnt == '0));

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !force_upd) |=> (cnt == '0));

    // R1
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !ovf && !force_upd) |=>
            (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R5
    gate_low_chk: assert property (@(posedge clk) disable iff (rst)
        !gate |-> (pwm_p == '0 && pwm_n == '0));

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (preload && !ovf && !force_upd) |=> $stable(arr_act));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_off
        // R4
        true_off_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg[c].on |-> !pwm_p[c]);
        // R4
        comp_off_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg[c].cmp_on |-> !pwm_n[c]);
    end

endmodule

bind pwm_quad_core pwm_quad_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run_w),
    .preload   (preload_w),
    .force_upd (force_w),
    .gate      (gate_w),
    .ovf       (ovf_w),
    .cnt       (cnt_w),
    .arr_act   (arr_w),
    .cfg       (cfg_w),
    .pwm_p     (pwm_p),
    .pwm_n     (pwm_n)
);

// File: tb/pwm_quad_core_test.sv
module pwm_quad_core_test;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [3:0]        wr_addr;
    logic [CNT_W-1:0]  wr_data;
    logic [NUM_CH-1:0] pwm_p, pwm_n;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int        cm [NUM_CH];
    logic [15:0] cfgv;
    bit        gatev;

    always #10 clk = ~clk;

    pwm_quad_core #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) uut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_p   (pwm_p),
        .pwm_n   (pwm_n)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [7:0] expect_out(input int cnt);
        logic [3:0] p, n;
        for (int c = 0; c < NUM_CH; c++) begin
            logic r;
            r    = (cnt < cm[c]);
            p[c] = gatev & cfgv[4*c] & (r ^ cfgv[4*c+1]);
            n[c] = gatev & cfgv[4*c+2] & (~r ^ cfgv[4*c+3]);
        end
        return {n, p};
    endfunction

    task automatic sweep(input int psc, input int arr, input logic [15:0] cf,
                         input bit g, input string tag);
        cm[0] = 0; cm[1] = 1; cm[2] = arr; cm[3] = arr + 1;
        cfgv = cf; gatev = g;
        wr(4'd0, 1);
        wr(4'd1, psc);
        wr(4'd2, arr);
        for (int c = 0; c < NUM_CH; c++) wr(4'(8 + c), cm[c]);
        wr(4'd4, {15'd0, g, cf});
        wr(4'd3, 1);
        for (int k = 0; k < 2 * (arr + 1) * (psc + 1); k++) begin
            check(tag, {pwm_n, pwm_p}, expect_out((k / (psc + 1)) % (arr + 1)));
            @(negedge clk);
        end
    endtask

    task automatic one_chan(input int psc, input int arr, input int cmp0, input int ctrl);
        cm[0] = cmp0; cm[1] = 0; cm[2] = 0; cm[3] = 0;
        cfgv = 16'h0001; gatev = 1'b1;
        wr(4'd0, ctrl);
        wr(4'd1, psc);
        wr(4'd2, arr);
        for (int c = 0; c < NUM_CH; c++) wr(4'(8 + c), cm[c]);
        wr(4'd4, 32'h0001_0001);
        wr(4'd3, 1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: outputs low after reset
        check("R12", {pwm_n, pwm_p}, 8'h00);

        // R1 R2 R3: sweep prescaler and reload, mixed polarity, all compare corners
        for (int psc = 0; psc < 3; psc++) begin
            foreach (cm[i]) cm[i] = 0;
            sweep(psc, 0, 16'hF531, 1'b1, "R1 R2 R3");
            sweep(psc, 1, 16'hF531, 1'b1, "R1 R2 R3");
            sweep(psc, 3, 16'hF531, 1'b1, "R1 R2 R3");
            sweep(psc, 5, 16'hF531, 1'b1, "R1 R2 R3");
        end
        // R4: enable bits off for some outputs
        sweep(1, 3, 16'h63C4, 1'b1, "R4");
        sweep(0, 5, 16'h0000, 1'b1, "R4");
        // R5: main gate closed
        sweep(0, 3, 16'hFFFF, 1'b0, "R5");

        // R6: preload on, compare change waits for wrap
        one_chan(0, 7, 6, 3);
        wr(4'd8, 2);
        for (int k = 1; k < 16; k++) begin
            check("R6", {7'd0, pwm_p[0]}, {7'd0, (k < 8) ? (k < 6) : ((k - 8) < 2)});
            @(negedge clk);
        end

        // R7: preload off, compare change immediate
        one_chan(0, 7, 6, 1);
        wr(4'd8, 2);
        for (int k = 1; k < 8; k++) begin
            check("R7", {7'd0, pwm_p[0]}, {7'd0, k < 2});
            @(negedge clk);
        end

        // R9: write lands on the wrap edge
        one_chan(0, 3, 1, 3);
        repeat (3) @(negedge clk);
        check("R9", {7'd0, pwm_p[0]}, 8'd0);
        wr(4'd8, 3);
        for (int k = 4; k < 12; k++) begin
            check("R9", {7'd0, pwm_p[0]}, {7'd0, ((k - 4) % 4) < 3});
            @(negedge clk);
        end

        // R11: prescaler write waits for update
        one_chan(2, 1, 1, 1);
        wr(4'd1, 0);
        for (int k = 1; k < 12; k++) begin
            check("R11", {7'd0, pwm_p[0]},
                  {7'd0, (k < 6) ? (k < 3) : (((k - 6) % 2) == 0)});
            @(negedge clk);
        end

        // R8: forced update mid-count restarts counter and prescaler
        one_chan(2, 3, 1, 1);
        repeat (4) @(negedge clk);
        wr(4'd3, 1);
        for (int k = 0; k < 12; k++) begin
            check("R8", {7'd0, pwm_p[0]}, {7'd0, k < 3});
            @(negedge clk);
        end

        // R10: run clear holds the counter
        one_chan(0, 7, 1, 0);
        for (int k = 0; k < 10; k++) begin
            check("R10", {7'd0, pwm_p[0]}, 8'd1);
            @(negedge clk);
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule